// File: doc/BRIEF.md
# Asynchronous Pseudo-Static RAM Controller

This block turns single-word read and write requests from an internal synchronous bus into the pin sequences of an asynchronous pseudo-static RAM. The memory holds 512K words of 16 bits. It has two chip selects of opposite polarity, an output enable, a write enable and one active-low enable for each byte lane. Each request carries a direction flag, a 19-bit word address, 16 bits of write data and a 2-bit lane mask. The request is taken with a valid/ready handshake. A one-cycle done pulse ends the access, and on reads the data comes back with it.

Every phase of an access lasts a parameter's worth of system clocks:

- read access wait
- address setup
- strobe width, which is the larger of the pulse-width and data-setup counts
- data hold
- bus turnaround after a read

A parameter picks the write style. In one style the write enable carries the strobe. In the other, both chip selects carry it together. Between accesses the controller keeps the memory deselected and its own data driver off. Every strobe comes straight from a flop.

Top module: `psram_ctrl`

## Requirements
- R1: After reset, `req_ready` is high, `rsp_done` is low, `mem_ce_n`=1, `mem_ce2`=0, `mem_oe_n`=1 and `mem_we_n`=1, and the controller leaves `mem_dq` undriven.
- R2: A read accepted at a clock edge holds `mem_ce_n`=0, `mem_ce2`=1, `mem_oe_n`=0 and `mem_we_n`=1 while it samples, and returns the stored word on `rsp_rdata` in the cycle `rsp_done` is high.
- R3: Mask bit 0 drives `mem_lb_n` low and covers data bits 7:0. Mask bit 1 drives `mem_ub_n` low and covers bits 15:8. A write leaves the lanes that are off unchanged, and a read returns zero in the lanes that are off.
- R4: A read keeps output enable low with the chip selected for exactly T_ACC clocks, so `rsp_done` rises T_ACC clocks after the accept edge.
- R5: With the write-enable strobe, address and data are presented T_AS clocks before `mem_we_n` falls. `mem_we_n` stays low for max(T_PW,T_DS) clocks, and the data stays driven T_DH clocks after it rises. `rsp_done` comes T_AS+max(T_PW,T_DS)+T_DH clocks after the accept.
- R6: With the chip-select strobe, `mem_we_n` is low for the whole write. The chip-select pair is active for max(T_PW,T_DS) clocks after T_AS setup clocks, and the write window closes on the chip selects while `mem_we_n` is still low. The setup, hold and done timing are the same as in R5.
- R7: The controller drives `mem_dq` only during writes and never while `mem_oe_n` is low. `mem_oe_n` is never low while `mem_we_n` is low.
- R8: After a read's done pulse, `req_ready` stays low for exactly T_TA clocks. During that time output enable is high and the data driver is off.
- R9: A request is taken only on an edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from the accept until the access (and any turnaround) ends, and `rsp_done` is high for one cycle per access.
- R10: Address and byte enables stay stable while the chip is selected. Changes on the request inputs during an access have no effect on it.
- R11: Whenever the controller is idle, the memory is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane enables, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with rsp_done |
| mem_addr | output | 19 | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_ce2 | output | 1 | Chip select, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Low byte enable, active low |
| mem_ub_n | output | 1 | High byte enable, active low |
| mem_dq | inout | 16 | Data bus |

## Verification
A wrong phase counter or a state that jumps ahead shows up quickly. The done pulse moves off its expected cycle on the same access, and the memory models measure a setup, strobe or hold length that differs from the parameters, which is reported when that phase ends. A stale lane register or a missed write commit stays hidden until the address is read back, so every random write is later met by reads of the same small address pool under varied masks. The bench runs both write styles in lockstep. If the strobe is assigned to the wrong pin, the models report it at the first write.

// File: rtl/psram_ctrl.sv
module psram_ctrl #(
  parameter int AW       = 19,
  parameter int DW       = 16,
  parameter int T_ACC    = 18,
  parameter int T_AS     = 2,
  parameter int T_PW     = 12,
  parameter int T_DS     = 5,
  parameter int T_DH     = 2,
  parameter int T_TA     = 1,
  parameter bit CE_STROBE = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    req_mask,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_ce2,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic          mem_lb_n,
  output logic          mem_ub_n,
  inout  wire  [DW-1:0] mem_dq
);
  localparam int P_CYC = (T_PW > T_DS) ? T_PW : T_DS;
  localparam int MAXC  = (T_ACC > P_CYC) ? T_ACC : P_CYC;
  localparam int CW    = $clog2(MAXC + 1) + 1;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_PULSE, S_HOLD, S_READ, S_TURN} state_t;

  state_t        state;
  logic [CW-1:0] cnt, lim;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic [1:0]    be_n_q;
  logic          sel_q, oe_n_q, we_n_q, dq_oe, done_q;
  logic          last;
  logic [DW-1:0] lane_mask;

  assign req_ready = (state == S_IDLE);
  assign rsp_done  = done_q;
  assign rsp_rdata = rdata_q;
  assign mem_addr  = addr_q;
  assign mem_ce_n  = ~sel_q;
  assign mem_ce2   = sel_q;
  assign mem_oe_n  = oe_n_q;
  assign mem_we_n  = we_n_q;
  assign mem_lb_n  = be_n_q[0];
  assign mem_ub_n  = be_n_q[1];
  assign mem_dq    = dq_oe ? wdata_q : {DW{1'bz}};
  assign lane_mask = {{(DW/2){~be_n_q[1]}}, {(DW/2){~be_n_q[0]}}};

  always_comb begin
    case (state)
      S_SETUP: lim = CW'(T_AS);
      S_PULSE: lim = CW'(P_CYC);
      S_HOLD:  lim = CW'(T_DH);
      S_READ:  lim = CW'(T_ACC);
      S_TURN:  lim = CW'(T_TA);
      default: lim = CW'(1);
    endcase
  end
  assign last = (cnt == lim - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      be_n_q  <= 2'b11;
      sel_q   <= 1'b0;
      oe_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      dq_oe   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      cnt    <= (state == S_IDLE || last) ? '0 : cnt + CW'(1);
      case (state)
        S_IDLE: if (req_valid) begin
          addr_q <= req_addr;
          be_n_q <= ~req_mask;
          if (req_write) begin
            wdata_q <= req_wdata;
            dq_oe   <= 1'b1;
            if (CE_STROBE) we_n_q <= 1'b0;
            else           sel_q  <= 1'b1;
            state <= S_SETUP;
          end else begin
            sel_q  <= 1'b1;
            oe_n_q <= 1'b0;
            state  <= S_READ;
          end
        end
        S_SETUP: if (last) begin
          if (CE_STROBE) sel_q  <= 1'b1;
          else           we_n_q <= 1'b0;
          state <= S_PULSE;
        end
        S_PULSE: if (last) begin
          if (CE_STROBE) sel_q  <= 1'b0;
          else           we_n_q <= 1'b1;
          state <= S_HOLD;
        end
        S_HOLD: if (last) begin
          dq_oe  <= 1'b0;
          sel_q  <= 1'b0;
          we_n_q <= 1'b1;
          be_n_q <= 2'b11;
          done_q <= 1'b1;
          state  <= S_IDLE;
        end
        S_READ: if (last) begin
          rdata_q <= mem_dq & lane_mask;
          sel_q   <= 1'b0;
          oe_n_q  <= 1'b1;
          be_n_q  <= 2'b11;
          done_q  <= 1'b1;
          state   <= S_TURN;
        end
        S_TURN: if (last) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  p_idle_desel_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n || !mem_ce2 || (mem_lb_n && mem_ub_n)));
  p_no_drive_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> mem_oe_n);
  p_oe_we_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> mem_we_n);
  p_addr_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_ce2 && $past(mem_ce2)) |-> ($stable(mem_addr) && $stable({mem_ub_n, mem_lb_n})));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  p_turn_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> $past(mem_oe_n));
  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_valid) |=> !req_ready);
endmodule

// File: tb/sim_psram_ctrl.sv
`timescale 1ns/1ps
module psram_model #(
  parameter int T_ACC = 18, T_AS = 2, P_CYC = 12, T_DH = 2, T_TA = 1,
  parameter bit CE_STROBE = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [18:0] addr,
  input  logic        ce_n, ce2, oe_n, we_n, lb_n, ub_n,
  inout  wire  [15:0] dq,
  output int          n_chk,
  output int          n_err
);
  logic [15:0] m [logic [18:0]];
  logic        sel, rd, wact, cd;
  logic        dval;
  logic [15:0] dword;
  logic        prev_wact, prev_drv, in_post;
  int          act_run, pre_run, post_run, since_oe, rcnt;
  logic [18:0] wa;
  logic [1:0]  wbe;
  logic [15:0] wd;

  assign sel  = !ce_n && ce2 && !(lb_n && ub_n);
  assign rd   = sel && !oe_n && we_n;
  assign wact = sel && !we_n;
  assign cd   = !rd && (dq !== 16'hzzzz);
  assign dq[7:0]  = (rd && !lb_n) ? (dval ? dword[7:0]  : 8'hxx) : 8'hzz;
  assign dq[15:8] = (rd && !ub_n) ? (dval ? dword[15:8] : 8'hxx) : 8'hzz;

  task automatic mchk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s (style %0d) actual %0d expected %0d", req, CE_STROBE, act, exp);
    end
  endtask

  initial begin
    n_chk = 0; n_err = 0; dval = 0; dword = 0; prev_wact = 0; prev_drv = 0; in_post = 0;
    act_run = 0; pre_run = 0; post_run = 0; since_oe = 1000; rcnt = 0;
    wa = 0; wbe = 0; wd = 0;
  end

  always @(negedge clk) if (rst_n) begin
    if (!oe_n) since_oe = 0; else if (since_oe < 1000) since_oe++;
    if (sel && !oe_n && !we_n) mchk(0, "R7 oe with we", 1, 0);
    if (cd && !prev_drv) mchk(since_oe > T_TA, "R8 turnaround before drive", since_oe, T_TA + 1);
    if (wact && !prev_wact) begin
      mchk(pre_run == T_AS, CE_STROBE ? "R6 setup" : "R5 setup", pre_run, T_AS);
      act_run = 0;
      wa = addr;
    end
    if (wact) begin
      act_run++;
      if (addr !== wa) mchk(0, "R10 address moved in write", int'(addr), int'(wa));
      wbe = {!ub_n, !lb_n};
      wd  = dq;
    end
    if (!wact && prev_wact) begin
      mchk(act_run == P_CYC, CE_STROBE ? "R6 strobe width" : "R5 strobe width", act_run, P_CYC);
      if (CE_STROBE) mchk(!we_n && !sel, "R6 closed by chip select", we_n, 0);
      else           mchk(we_n && sel, "R5 closed by write enable", sel, 1);
      begin
        logic [15:0] o;
        o = m.exists(wa) ? m[wa] : 16'h0;
        if (wbe[0]) o[7:0]  = wd[7:0];
        if (wbe[1]) o[15:8] = wd[15:8];
        m[wa] = o;
      end
      in_post = 1; post_run = 0;
    end
    if (in_post && cd) post_run++;
    if (in_post && !cd && prev_drv) begin
      mchk(post_run == T_DH, CE_STROBE ? "R6 hold" : "R5 hold", post_run, T_DH);
      in_post = 0;
    end
    if (cd && !wact && !in_post) pre_run++; else if (!cd) pre_run = 0;
    if (rd) begin
      rcnt++;
      if (rcnt >= T_ACC) begin
        dval  = 1;
        dword = m.exists(addr) ? m[addr] : 16'h0;
      end
    end else begin
      rcnt = 0; dval = 0;
    end
    prev_wact = wact;
    prev_drv  = cd;
  end
endmodule

module sim_psram_ctrl;
  localparam int T_ACC = 18, T_AS = 2, T_PW = 12, T_DS = 5, T_DH = 2, T_TA = 1;
  localparam int P_CYC = (T_PW > T_DS) ? T_PW : T_DS;

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic        req_valid = 0, req_write = 0;
  logic [18:0] req_addr = 0;
  logic [15:0] req_wdata = 0;
  logic [1:0]  req_mask = 0;
  logic        rdy0, rdy1, done0, done1;
  logic [15:0] rdata0, rdata1;
  logic [18:0] a0, a1;
  logic        ce_n0, ce20, oe_n0, we_n0, lb_n0, ub_n0;
  logic        ce_n1, ce21, oe_n1, we_n1, lb_n1, ub_n1;
  wire  [15:0] dq0, dq1;
  int          mc0, me0, mc1, me1;
  int          checks = 0, errors = 0;
  bit          finished = 0;

  psram_ctrl #(.T_ACC(T_ACC), .T_AS(T_AS), .T_PW(T_PW), .T_DS(T_DS), .T_DH(T_DH), .T_TA(T_TA),
               .CE_STROBE(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy0), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask), .rsp_done(done0),
    .rsp_rdata(rdata0), .mem_addr(a0), .mem_ce_n(ce_n0), .mem_ce2(ce20), .mem_oe_n(oe_n0),
    .mem_we_n(we_n0), .mem_lb_n(lb_n0), .mem_ub_n(ub_n0), .mem_dq(dq0));
  psram_ctrl #(.T_ACC(T_ACC), .T_AS(T_AS), .T_PW(T_PW), .T_DS(T_DS), .T_DH(T_DH), .T_TA(T_TA),
               .CE_STROBE(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy1), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask), .rsp_done(done1),
    .rsp_rdata(rdata1), .mem_addr(a1), .mem_ce_n(ce_n1), .mem_ce2(ce21), .mem_oe_n(oe_n1),
    .mem_we_n(we_n1), .mem_lb_n(lb_n1), .mem_ub_n(ub_n1), .mem_dq(dq1));

  psram_model #(.T_ACC(T_ACC), .T_AS(T_AS), .P_CYC(P_CYC), .T_DH(T_DH), .T_TA(T_TA), .CE_STROBE(1'b0)) m0 (
    .clk(clk), .rst_n(rst_n), .addr(a0), .ce_n(ce_n0), .ce2(ce20), .oe_n(oe_n0), .we_n(we_n0),
    .lb_n(lb_n0), .ub_n(ub_n0), .dq(dq0), .n_chk(mc0), .n_err(me0));
  psram_model #(.T_ACC(T_ACC), .T_AS(T_AS), .P_CYC(P_CYC), .T_DH(T_DH), .T_TA(T_TA), .CE_STROBE(1'b1)) m1 (
    .clk(clk), .rst_n(rst_n), .addr(a1), .ce_n(ce_n1), .ce2(ce21), .oe_n(oe_n1), .we_n(we_n1),
    .lb_n(lb_n1), .ub_n(ub_n1), .dq(dq1), .n_chk(mc1), .n_err(me1));

  logic [15:0] exp_mem [16];

  function automatic logic [18:0] pool_addr(input int i);
    if (i == 0)  return 19'h0;
    if (i == 15) return 19'h7FFFF;
    return 19'((i * 32'h9E37) & 32'h7FFFF);
  endfunction

  function automatic logic [15:0] lanes(input logic [1:0] mk);
    return {{8{mk[1]}}, {8{mk[0]}}};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_op(input bit w, input int idx, input logic [1:0] mk, input logic [15:0] d);
    int lat;
    int exp_lat;
    logic [15:0] expd;
    exp_lat = w ? (T_AS + P_CYC + T_DH) : T_ACC;
    expd = exp_mem[idx] & lanes(mk);
    req_valid = 1; req_write = w; req_addr = pool_addr(idx); req_wdata = d; req_mask = mk;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; req_addr = ~req_addr; req_wdata = ~req_wdata; req_mask = ~req_mask;
    req_write = ~req_write;
    chk(!rdy0 && !rdy1, "R9 ready low while busy", {rdy1, rdy0}, 0);
    lat = 0;
    while (!(done0 && done1) && lat < 1000) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == exp_lat, w ? "R5/R6 write done latency" : "R4 read done latency", lat, exp_lat);
    if (!w) begin
      chk(rdata0 == expd, "R2/R3 read data WE-style", rdata0, expd);
      chk(rdata1 == expd, "R2/R3 read data CE-style", rdata1, expd);
      lat = 0;
      while (!(rdy0 && rdy1) && lat < 1000) begin
        @(negedge clk);
        lat++;
      end
      chk(lat == T_TA, "R8 turnaround length", lat, T_TA);
    end else begin
      if (mk[0]) exp_mem[idx][7:0]  = d[7:0];
      if (mk[1]) exp_mem[idx][15:8] = d[15:8];
      @(negedge clk);
      chk(rdy0 && rdy1, "R9 ready after write", {rdy1, rdy0}, 3);
    end
    @(negedge clk);
    chk(!done0 && !done1, "R9 done one cycle", {done1, done0}, 0);
  endtask

  initial begin
    void'($urandom(32'h5EED));
    for (int i = 0; i < 16; i++) exp_mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    chk(rdy0 && rdy1 && !done0 && !done1, "R1 ready/done after reset", {rdy1, rdy0, done1, done0}, 4'b1100);
    chk(ce_n0 && !ce20 && oe_n0 && we_n0, "R1 strobes idle WE-style", {ce_n0, ce20, oe_n0, we_n0}, 4'b1011);
    chk(ce_n1 && !ce21 && oe_n1 && we_n1, "R11 strobes idle CE-style", {ce_n1, ce21, oe_n1, we_n1}, 4'b1011);
    chk(dq0 === 16'hzzzz && dq1 === 16'hzzzz, "R1 bus released", 0, 0);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < 16; i++) do_op(1, i, 2'b11, 16'(i * 16'h1111 ^ 16'hA5C3));
    for (int i = 0; i < 16; i++) do_op(0, i, 2'b11, 16'h0);
    do_op(1, 3, 2'b01, 16'hBEEF);
    do_op(0, 3, 2'b11, 16'h0);
    do_op(1, 3, 2'b10, 16'hCAFE);
    do_op(0, 3, 2'b01, 16'h0);
    do_op(0, 3, 2'b10, 16'h0);
    do_op(1, 15, 2'b00, 16'h1234);
    do_op(0, 15, 2'b11, 16'h0);
    do_op(0, 0, 2'b11, 16'h0);
    do_op(1, 0, 2'b11, 16'hFFFF);
    do_op(0, 0, 2'b11, 16'h0);
    for (int n = 0; n < 160; n++) begin
      do_op(1'($urandom_range(0, 1)), int'($urandom_range(0, 15)), 2'($urandom_range(0, 3)),
            16'($urandom));
      if (ce_n0 !== 1'b1 || ce_n1 !== 1'b1) chk(0, "R11 idle deselect", {ce_n1, ce_n0}, 3);
    end
    repeat (4) @(negedge clk);
    checks += mc0 + mc1;
    errors += me0 + me1;
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks + mc0 + mc1, errors + me0 + me1);
      $finish;
    end
  end
endmodule